// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block turns four asynchronous external interrupt request pins into four qualified request outputs. Each pin is first brought into the clock domain through a synchroniser chain. It is then checked against a per-line sense mode, which is either a level of either polarity or an edge of either direction. Edge events are caught in a sticky latch, which holds the request until software acknowledges it. Level conditions are passed straight through and need no acknowledge.

All configuration sits in one 32-bit control word behind a simple write-strobe and read-data port. The sense fields, line enables and acknowledge strobes for the four lines sit at mirrored positions that descend as the line number rises. The same word also holds a master enable for all external lines and a flag that selects normal routing of the critical interrupt. Both of these are brought out as outputs for the surrounding interrupt controller to use.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the control word reads 0x00000000, every qualified request is 0, and `master_en` and `crit_normal` are 0.
- R2: The sense mode of line n is held in control bits (23-2n):(22-2n). Its codes are 0 = active-high level, 1 = rising edge, 2 = falling edge and 3 = active-low level. The field is read/write.
- R3: Control bit (11-n) enables line n, and is read/write. `irq_req[n]` is 1 only when that bit, the master enable and the line's sensed condition are all 1.
- R4: Writing 1 to control bit (27-n) clears the edge latch of line n. Writing 0 there leaves the latch unchanged. Bits 27:24 always read as 0.
- R5: Control bit 12 is the master enable, driven on `master_en`. Control bit 0 is the critical-routing flag, driven on `crit_normal`. Both are read/write. Bits 31:28, 15:13 and 7:1 read as 0, and writes to them are ignored.
- R6: In a level mode, the condition equals the synchronised pin (inverted for active-low). A pin change reaches `irq_req` after SYNC_STAGES rising clock edges.
- R7: In an edge mode, a matching transition of the synchronised pin sets the line's latch. The request is visible SYNC_STAGES+1 edges after the pin change. It stays set until acknowledged, and a new event in the same cycle as an acknowledge keeps the latch set.
- R8: Edge events are latched whether or not the line or master enable is set. Enabling a line later then presents the pending event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control word read-back |
| irq_pin | input | 4 | Raw asynchronous request pins, bit n = line n |
| irq_req | output | 4 | Qualified request per line |
| master_en | output | 1 | Master external enable |
| crit_normal | output | 1 | Critical interrupt normal-routing flag |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. This gives a level change a two-edge latency and an edge event a three-edge latency, and the bench model tracks both exactly cycle by cycle. A single synchroniser depth is enough to reach every sense mode, every acknowledge-versus-event collision and every enable gating, because all four lines share the same pipeline depth. Random pin toggling, mixed with random control writes, drives lines through mode changes while events are pending, including ones latched while the line is disabled.

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [3:0]  irq_pin,
  output logic [3:0]  irq_req,
  output logic        master_en,
  output logic        crit_normal
);
  localparam int NL = 4;

  logic [NL-1:0] sync_q [SYNC_STAGES];
  logic [NL-1:0] prev_q;
  logic [NL-1:0] latch_q;
  logic [7:0]    sense_q;
  logic [3:0]    en_q;
  logic          master_q;
  logic          crit_q;
  logic [NL-1:0] pin_s;
  logic [NL-1:0] edge_ev;
  logic [NL-1:0] ack;
  logic [NL-1:0] cond;
  logic [NL-1:0] line_en;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= irq_pin;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q  <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
      crit_q   <= 1'b0;
    end else if (wr_en) begin
      sense_q  <= wr_data[23:16];
      en_q     <= wr_data[11:8];
      master_q <= wr_data[12];
      crit_q   <= wr_data[0];
    end
  end

  for (genvar n = 0; n < NL; n++) begin : g_line
    logic [1:0] mode;
    assign mode       = sense_q[7-2*n -: 2];
    assign line_en[n] = en_q[3-n];
    assign ack[n]     = wr_en & wr_data[27-n];
    assign edge_ev[n] = (mode == 2'd1) ? (pin_s[n] & ~prev_q[n]) :
                        (mode == 2'd2) ? (~pin_s[n] & prev_q[n]) : 1'b0;
    assign cond[n]    = (mode == 2'd0) ? pin_s[n] :
                        (mode == 2'd3) ? ~pin_s[n] : latch_q[n];

    always_ff @(posedge clk) begin
      if (!rst_n)          latch_q[n] <= 1'b0;
      else if (edge_ev[n]) latch_q[n] <= 1'b1;
      else if (ack[n])     latch_q[n] <= 1'b0;
    end

    a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q[n] && !(wr_en && wr_data[27-n])) |=> latch_q[n]);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[27-n] && !edge_ev[n]) |=> !latch_q[n]);
  end

  assign irq_req     = cond & line_en & {NL{master_q}};
  assign master_en   = master_q;
  assign crit_normal = crit_q;
  assign rd_data     = {8'h00, sense_q, 3'b000, master_q, en_q, 7'h00, crit_q};

  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~line_en) == '0 && (master_en || irq_req == '0));
  a_r4_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[27:24] == 4'h0);
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:28] == 4'h0 && rd_data[15:13] == 3'h0 && rd_data[7:1] == 7'h0);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 32'h0 && latch_q == '0));
endmodule

// File: tb/ext_irq_cond_tb.sv
module ext_irq_cond_tb;
  localparam int SS = 2;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] irq_pin = '0, irq_req;
  logic master_en, crit_normal;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_cond #(.SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_pin(irq_pin), .irq_req(irq_req), .master_en(master_en), .crit_normal(crit_normal));

  logic [3:0] m_sync [SS];
  logic [3:0] m_prev = '0, m_latch = '0;
  logic [31:0] m_ctl = '0;

  function automatic logic [1:0] mode_of(logic [31:0] c, int n);
    return c[23-2*n -: 2];
  endfunction

  function automatic logic [3:0] exp_req(logic [31:0] c, logic [3:0] s, logic [3:0] l);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      logic cnd;
      case (mode_of(c, n))
        2'd0: cnd = s[n];
        2'd3: cnd = ~s[n];
        default: cnd = l[n];
      endcase
      r[n] = cnd & c[11-n] & c[12];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SS; i++) m_sync[i] <= '0;
      m_prev <= '0; m_latch <= '0; m_ctl <= '0;
    end else begin
      m_sync[0] <= irq_pin;
      for (int i = 1; i < SS; i++) m_sync[i] <= m_sync[i-1];
      m_prev <= m_sync[SS-1];
      if (wr_en) m_ctl <= wr_data & 32'h00FF_1F01;
      for (int n = 0; n < 4; n++) begin
        logic ev;
        logic [1:0] md;
        md = mode_of(m_ctl, n);
        ev = (md == 2'd1) ? (m_sync[SS-1][n] & ~m_prev[n]) :
             (md == 2'd2) ? (~m_sync[SS-1][n] & m_prev[n]) : 1'b0;
        if (ev) m_latch[n] <= 1'b1;
        else if (wr_en && wr_data[27-n]) m_latch[n] <= 1'b0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison two time units after every edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [3:0] e;
      e = exp_req(m_ctl, m_sync[SS-1], m_latch);
      for (int n = 0; n < 4; n++)
        chk((mode_of(m_ctl, n) == 2'd0 || mode_of(m_ctl, n) == 2'd3) ? "R6 level request" : "R7 edge request",
            {31'b0, irq_req[n]}, {31'b0, e[n]});
      chk("R2/R3/R4/R5 read-back", rd_data, m_ctl);
      chk("R5 master_en", {31'b0, master_en}, {31'b0, m_ctl[12]});
      chk("R5 crit_normal", {31'b0, crit_normal}, {31'b0, m_ctl[0]});
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic pins(logic [3:0] p, int wait_cyc);
    @(negedge clk); irq_pin = p;
    repeat (wait_cyc) @(negedge clk);
  endtask

  initial begin
    fork
      begin repeat (100000) @(posedge clk); n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish"); done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad); $finish; end
    join_none
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset irq_req", {28'b0, irq_req}, 32'h0);
    // R7: line 0 rising edge, visible after SS+1 edges
    wr(32'h0040_1800);
    @(negedge clk); irq_pin = 4'b0001;
    repeat (SS) @(negedge clk);
    chk("R7 not yet visible", {28'b0, irq_req}, 32'h0);
    @(negedge clk);
    chk("R7 edge latched", {28'b0, irq_req}, 32'h1);
    pins(4'b0000, 4);
    chk("R7 held after pin low", {28'b0, irq_req}, 32'h1);
    // R4: ack written as 0 keeps the latch, ack 1 clears
    wr(32'h0040_1800);
    chk("R4 write-0 no effect", {28'b0, irq_req}, 32'h1);
    wr(32'h0840_1800);
    chk("R4 ack clears", {28'b0, irq_req}, 32'h0);
    // R6: line 1 active-low level
    wr(32'h0030_1400);
    pins(4'b0010, 3);
    chk("R6 low level inactive", {28'b0, irq_req}, 32'h0);
    pins(4'b0000, 3);
    chk("R6 low level active", {28'b0, irq_req}, 32'h2);
    // R8: line 3 falling edge while disabled, then enable
    wr(32'h0002_0000);
    pins(4'b1000, 4);
    pins(4'b0000, 4);
    chk("R8 disabled gated", {28'b0, irq_req}, 32'h0);
    wr(32'h0002_1100);
    chk("R8 pending event shown", {28'b0, irq_req}, 32'h8);
    // R7: event collides with ack; line 2 rising
    wr(32'h0004_1200);
    @(negedge clk); irq_pin = 4'b0100;
    repeat (SS) @(negedge clk);
    wr_en = 1; wr_data = 32'h0204_1200;
    @(negedge clk); wr_en = 0; wr_data = '0;
    chk("R7 event beats ack", {28'b0, irq_req}, 32'h4);
    // random phase, model compares every cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_pin = 4'($urandom);
      if ($urandom_range(0, 9) == 0) begin
        wr_en = 1; wr_data = $urandom | ($urandom_range(0, 3) != 0 ? 32'h1000 : 0);
      end else begin
        wr_en = 0; wr_data = '0;
      end
    end
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule